// File: doc/BRIEF.md
# PCI Power Management Control/Status Register

This block is the 16-bit power management control and status word of a PCI function. It sits behind a simple configuration-space port that accepts reads and byte-enabled writes. Software uses the word to request a device power state (D0 to D3) and to allow or forbid wake signalling. It also uses the word to pick one of eight power consumption or dissipation ratings. The rating value and its scaling factor come from a small internal table.

A sticky status flag records every wake event, whether or not wake signalling is enabled. The registered wake output is driven only while the flag is set and enabled. Software clears the flag by writing 1 to it. The block has two resets. The bus reset clears every bit. The internal soft reset, which accompanies a return from D3hot to D0, leaves the register untouched.

Top module: `pm_ctrl_reg`

## Requirements
- R1: While `rst_ni` is low and after it is released, the power state is D0, the PME enable is 0, the PME status is 0, the data select is 0, `pme_o` is 0 and `rvalid_o` is 0. The word therefore reads 0x2000, because select 0 reports scale 1.
- R2: Bits [1:0] of the word hold the requested power state and are read/write, with 00=D0, 01=D1, 10=D2 and 11=D3. `pwr_state_o` shows the stored value.
- R3: Bit 8 holds the PME enable and is read/write. `pme_o` is a register loaded each cycle with (PME status AND PME enable), so it follows them one cycle later. While the enable is 0, `pme_o` stays 0.
- R4: A cycle with `pme_event_i` high sets the PME status (bit 15) at that clock edge, whatever the value of the enable.
- R5: A write that has `be_i[1]` set and data bit 15 equal to 1 clears the PME status. Data bit 15 equal to 0 leaves the status unchanged. If an event and a clearing write fall in the same cycle, the status stays set.
- R6: Bits [7:2] always read 0. This includes bit 4, the dynamic-data bit. Bits [14:13] are read-only, and writes to them are ignored.
- R7: Bits [12:9] hold a 4-bit data select and are read/write. For a select value s from 0 to 7, `pm_data_o` is 40+17*s and the scale field [14:13] is (s mod 3)+1. For s from 8 to 15, both read 0.
- R8: `soft_rst_i` has no effect on any field or on `pme_o`.
- R9: A request with `we_i` low returns the word on `rdata_o`, with `rvalid_o` high, one cycle later. The word is the value the register held at the request edge. A read at any address other than 0x48 returns 0. A write at any other address is ignored. `rvalid_o` is low in every cycle that does not follow a read request.
- R10: `be_i[0]` gates the write of bits [7:0] and `be_i[1]` gates the write of bits [15:8]. A write with a byte enable of 0 leaves that byte's fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Bus reset, active low, asynchronous |
| soft_rst_i | input | 1 | Internal soft reset (D3hot to D0); ignored by the register |
| req_i | input | 1 | Config access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Config byte offset |
| be_i | input | 2 | Byte enables for the write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| pme_event_i | input | 1 | Wake event from the function |
| pme_o | output | 1 | Registered wake output |
| pwr_state_o | output | 2 | Current requested power state |
| pm_data_o | output | 8 | Selected power rating |

## Verification
The hardest case to reach is a wake event that arrives in the same cycle as a write-1-to-clear. The bench schedules the clearing write and the event pulse on the same falling edge, so both are seen at one rising edge, and then reads the status back. The second hard case is a soft reset that follows a fully populated register. To reach it, the bench first loads D3, enable, a non-zero select and a pending status. It then holds `soft_rst_i` for several cycles and re-reads the whole word and `pme_o`.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int PM_WORD_W  = 16;
  localparam int PM_SEL_W   = 4;
  localparam int PM_SCALE_W = 2;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pwr_state_e;

  // word bit positions
  localparam int BIT_PME_EN  = 8;
  localparam int BIT_SEL_LO  = 9;
  localparam int BIT_SCL_LO  = 13;
  localparam int BIT_PME_STS = 15;
endpackage

// File: rtl/pm_data_table.sv
module pm_data_table
  import pm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_ENT  = 8,
  parameter int BASE   = 40,
  parameter int STEP   = 17
) (
  input  logic [PM_SEL_W-1:0]   sel_i,
  output logic [DATA_W-1:0]     data_o,
  output logic [PM_SCALE_W-1:0] scale_o
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [DATA_W-1:0]     data_tbl  [N_ENT];
  logic [PM_SCALE_W-1:0] scale_tbl [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign data_tbl[g]  = DATA_W'(BASE + STEP * g);
    assign scale_tbl[g] = PM_SCALE_W'((g % 3) + 1);
  end

  logic [IDX_W-1:0] idx;
  assign idx = sel_i[IDX_W-1:0];

  always_comb begin
    if (int'(sel_i) < N_ENT) begin
      data_o  = data_tbl[idx];
      scale_o = scale_tbl[idx];
    end else begin
      data_o  = '0;
      scale_o = '0;
    end
  end
endmodule

// File: rtl/pm_pme_logic.sv
module pm_pme_logic (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic clr_i,
  input  logic en_i,
  output logic sts_o,
  output logic pme_o
);
  logic sts_q, pme_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
      pme_q <= 1'b0;
    end else begin
      sts_q <= event_i | (sts_q & ~clr_i);  // event wins over clear
      pme_q <= sts_q & en_i;
    end
  end

  assign sts_o = sts_q;
  assign pme_o = pme_q;
endmodule

// File: rtl/pm_cfg_port.sv
module pm_cfg_port #(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h48,
  parameter int              WORD_W   = 16,
  localparam int             BE_W     = WORD_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [BE_W-1:0]   wr_be_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic hit, rd;
  logic [WORD_W-1:0] rdata_q;
  logic rvalid_q;

  assign hit     = req_i && (addr_i == REG_ADDR);
  assign rd      = req_i && !we_i;
  assign wr_be_o = (hit && we_i) ? be_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= hit ? rd_word_i : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
  import pm_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h48,
  parameter int                DATA_W      = 8,
  parameter int                N_RATINGS   = 8,
  parameter int                RATING_BASE = 40,
  parameter int                RATING_STEP = 17
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 soft_rst_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           be_i,
  input  logic [15:0]          wdata_i,
  output logic [15:0]          rdata_o,
  output logic                 rvalid_o,
  input  logic                 pme_event_i,
  output logic                 pme_o,
  output logic [1:0]           pwr_state_o,
  output logic [DATA_W-1:0]    pm_data_o
);
  pwr_state_e            ps_q;
  logic                  en_q;
  logic [PM_SEL_W-1:0]   sel_q;
  logic                  sts_q;
  logic [PM_SCALE_W-1:0] scale;
  logic [1:0]            wr_be;
  logic [15:0]           rd_word;

  // soft reset deliberately not wired to any state
  logic unused_soft_rst;
  assign unused_soft_rst = soft_rst_i;
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[7:2], wdata_i[14:13]};

  pm_cfg_port #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .WORD_W  (PM_WORD_W)
  ) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .be_i     (be_i),
    .rd_word_i(rd_word),
    .wr_be_o  (wr_be),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q  <= PS_D0;
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      if (wr_be[0]) ps_q <= pwr_state_e'(wdata_i[1:0]);
      if (wr_be[1]) begin
        en_q  <= wdata_i[BIT_PME_EN];
        sel_q <= wdata_i[BIT_SEL_LO +: PM_SEL_W];
      end
    end
  end

  pm_pme_logic u_pme (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .event_i(pme_event_i),
    .clr_i  (wr_be[1] & wdata_i[BIT_PME_STS]),
    .en_i   (en_q),
    .sts_o  (sts_q),
    .pme_o  (pme_o)
  );

  pm_data_table #(
    .DATA_W(DATA_W),
    .N_ENT (N_RATINGS),
    .BASE  (RATING_BASE),
    .STEP  (RATING_STEP)
  ) u_tbl (
    .sel_i  (sel_q),
    .data_o (pm_data_o),
    .scale_o(scale)
  );

  assign rd_word     = {sts_q, scale, sel_q, en_q, 6'b0, ps_q};
  assign pwr_state_o = ps_q;
endmodule

// File: rtl/pm_ctrl_reg_chk.sv
module pm_ctrl_reg_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h48,
  parameter int                DATA_W    = 8,
  parameter int                N_RATINGS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              be_hi_i,
  input logic              wclr_i,
  input logic              pme_event_i,
  input logic              pme_o,
  input logic              rvalid_o,
  input logic [15:0]       rdata_o,
  input logic [DATA_W-1:0] pm_data_o,
  input logic [1:0]        pwr_state_o,
  input logic              en_q,
  input logic              sts_q,
  input logic [3:0]        sel_q
);
  logic clr_wr;
  assign clr_wr = req_i && we_i && (addr_i == REG_ADDR) && be_hi_i && wclr_i;

  AST_PME_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !pme_o); // R3
  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pme_event_i |=> sts_q); // R4
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !clr_wr) |=> sts_q); // R5
  AST_STS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !pme_event_i) |=> !sts_q); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o[7:2] == 6'b0)); // R6
  AST_HI_SEL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sel_q) >= N_RATINGS) |-> (pm_data_o == '0)); // R7
  AST_SOFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !req_i) |=> ($stable(pwr_state_o) && $stable(en_q) && $stable(sel_q))); // R8
  AST_RD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R9
  AST_NO_RD_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o); // R9
endmodule

bind pm_ctrl_reg pm_ctrl_reg_chk #(
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR),
  .DATA_W   (DATA_W),
  .N_RATINGS(N_RATINGS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .be_hi_i    (be_i[1]),
  .wclr_i     (wdata_i[15]),
  .pme_event_i(pme_event_i),
  .pme_o      (pme_o),
  .rvalid_o   (rvalid_o),
  .rdata_o    (rdata_o),
  .pm_data_o  (pm_data_o),
  .pwr_state_o(pwr_state_o),
  .en_q       (en_q),
  .sts_q      (sts_q),
  .sel_q      (sel_q)
);

// File: tb/pm_ctrl_reg_bench.sv
module pm_ctrl_reg_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic soft_rst_i = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [1:0] be_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic rvalid_o, pme_event_i = 1'b0, pme_o;
  logic [1:0] pwr_state_o;
  logic [7:0] pm_data_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] m_ps;
  logic m_en, m_sts;
  logic [3:0] m_sel;

  always #2.5 clk = ~clk;

  pm_ctrl_reg u_pm_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .pme_event_i(pme_event_i), .pme_o(pme_o),
    .pwr_state_o(pwr_state_o), .pm_data_o(pm_data_o)
  );

  function automatic logic [7:0] exp_data(input logic [3:0] s);
    return (s < 8) ? 8'(40 + 17 * s) : 8'd0;
  endfunction
  function automatic logic [1:0] exp_scale(input logic [3:0] s);
    return (s < 8) ? 2'((s % 3) + 1) : 2'd0;
  endfunction
  function automatic logic [15:0] exp_word();
    return {m_sts, exp_scale(m_sel), m_sel, m_en, 6'b0, m_ps};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk);
    req_i = 0; we_i = 0; be_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk);
    req_i = 0;
    checks++;
    if (rvalid_o !== 1'b1) begin
      errors++;
      $display("FAIL R9 rvalid act=%b exp=1", rvalid_o);
    end
    d = rdata_o;
  endtask

  task automatic pulse_event();
    @(negedge clk); pme_event_i = 1;
    @(negedge clk); pme_event_i = 0;
  endtask

  function automatic logic [15:0] hi_word(input logic clr);
    return {clr, 2'b11, m_sel, m_en, 8'h00};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    m_ps = 0; m_en = 0; m_sts = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    chk("R1 pme_o in reset", 16'(pme_o), 16'd0);
    chk("R1 rvalid in reset", 16'(rvalid_o), 16'd0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 pwr_state", 16'(pwr_state_o), 16'd0);
    chk("R1 pm_data", 16'(pm_data_o), 16'(exp_data(0)));
    rd(8'h48, d);
    chk("R1 word", d, 16'h2000);
    @(negedge clk);
    chk("R9 rvalid idle", 16'(rvalid_o), 16'd0);

    // R2 / R10 / R6: power state through low byte, reserved bits written as 1
    for (int p = 0; p < 4; p++) begin
      wr(8'h48, {8'hFF, 6'h3F, 2'(p)}, 2'b01);
      m_ps = 2'(p);
      chk("R2 pwr_state_o", 16'(pwr_state_o), 16'(p));
      rd(8'h48, d);
      chk("R10 R6 word after low write", d, exp_word());
      wr(8'h48, {8'h00, 6'h00, 2'(~p)}, 2'b10);  // low byte disabled
      rd(8'h48, d);
      chk("R10 low byte gated", 16'(d[1:0]), 16'(p));
    end

    // R7 / R6: sweep every select value, scale bits written as 1
    for (int s = 0; s < 16; s++) begin
      m_sel = 4'(s);
      wr(8'h48, hi_word(1'b0), 2'b10);
      chk("R7 pm_data_o", 16'(pm_data_o), 16'(exp_data(4'(s))));
      rd(8'h48, d);
      chk("R7 R6 word", d, exp_word());
    end
    m_sel = 0;
    wr(8'h48, hi_word(1'b0), 2'b10);

    // R9: other addresses
    rd(8'h44, d);
    chk("R9 miss read", d, 16'h0000);
    wr(8'h4C, 16'hFF03, 2'b11);
    rd(8'h48, d);
    chk("R9 miss write ignored", d, exp_word());

    // R3 / R4 / R5
    for (int e = 0; e < 2; e++) begin
      m_en = e[0];
      wr(8'h48, hi_word(1'b0), 2'b10);
      pulse_event();
      m_sts = 1;
      @(negedge clk);
      chk("R3 pme_o follows sts&en", 16'(pme_o), 16'(e));
      rd(8'h48, d);
      chk("R4 status set", d, exp_word());
      wr(8'h48, hi_word(1'b0), 2'b10);
      rd(8'h48, d);
      chk("R5 write 0 keeps status", d, exp_word());
      chk("R3 pme_o held", 16'(pme_o), 16'(e));
      wr(8'h48, hi_word(1'b1), 2'b10);
      m_sts = 0;
      @(negedge clk);
      chk("R5 pme_o dropped", 16'(pme_o), 16'd0);
      rd(8'h48, d);
      chk("R5 status cleared", d, exp_word());
    end
    // R5: event and clear in the same cycle
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = 8'h48; be_i = 2'b10;
    wdata_i = hi_word(1'b1); pme_event_i = 1;
    @(negedge clk);
    req_i = 0; we_i = 0; be_i = 0; pme_event_i = 0;
    m_sts = 1;
    rd(8'h48, d);
    chk("R5 event beats clear", d, exp_word());

    // R8: soft reset leaves a populated register alone
    m_ps = 2'b11; m_sel = 4'd5;
    wr(8'h48, {hi_word(1'b0)[15:8], 8'h03}, 2'b11);
    @(negedge clk); soft_rst_i = 1;
    repeat (4) @(negedge clk);
    soft_rst_i = 0;
    rd(8'h48, d);
    chk("R8 word kept", d, exp_word());
    chk("R8 pme_o kept", 16'(pme_o), 16'd1);
    chk("R8 pm_data kept", 16'(pm_data_o), 16'(exp_data(4'd5)));

    // R1: bus reset mid-run
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    m_ps = 0; m_en = 0; m_sts = 0; m_sel = 0;
    chk("R1 pme_o after reset", 16'(pme_o), 16'd0);
    rd(8'h48, d);
    chk("R1 word after reset", d, 16'h2000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule